// File: doc/BRIEF.md
# Delay-Line Calibration and Phase Tuner

This block is a hardware sequencer for a tapped receive-clock delay line. When started, it first calibrates the line. It steps the unit delay code upward from zero and reads back the line-length measurement for each code. It keeps the first code whose measured length shows that the line spans less than one clock period. The highest set bit of that length gives the largest usable tap.

It then sweeps the sampling tap from 0 up to that largest tap. For each tap it asks an external tuning-pattern checker, through a request/pass/fail handshake, whether the data samples correctly. It then settles on the centre of the longest run of consecutive passing taps.

The chosen configuration stays applied to the delay line after completion, until the next start request. A failure in either phase raises an error flag and returns the delay line to clock pass-through. The analog delay cells and the tuning command protocol lie outside the block.

Top module: `dlc_tuner`

## Requirements
- R1: After reset, `done`, `err` and `chk_req` are 0, and the delay-line controls `dl_en`, `dl_smp_en`, `dl_unit` and `dl_tap` are all 0 (clock pass-through).
- R2: During length calibration, `dl_en` and `dl_smp_en` are both 1 and `dl_tap` equals NB_DELAY+1 (12 by default). Unit codes are tried in ascending order starting from 0.
- R3: For each unit code, the sequencer waits for `dl_len_vld` for at most CYC_PER_US*TIMEOUT_US cycles. On timeout it moves on to the next code, so a silent code stays driven for that many waiting cycles plus one setup cycle.
- R4: A unit code is accepted when `dl_len_vld` is 1, `dl_len` is nonzero and `dl_len` is below 2^NB_DELAY. Any other valid measurement moves on to the next code, and the lowest acceptable code is reported on `cal_unit`.
- R5: `cal_max_tap` equals the bit index of the highest 1 in the accepted length. For example, 0x0F0 gives 7 and 0x7FF gives 10.
- R6: If no code up to 2^UNIT_W-1 is accepted, the block ends with `done`=1 and `err`=1, and all delay-line controls return to 0.
- R7: The phase sweep probes taps 0 to `cal_max_tap` in ascending order. Each tap gets exactly one `chk_req` pulse, with `dl_en`=1, `dl_smp_en`=0 and `dl_unit`=`cal_unit`. A `chk_pass` or `chk_fail` pulse answers each probe.
- R8: Across the sweep, a failing tap clears the current run length and a passing tap extends it. Only a strictly longer run replaces the recorded best, so the earliest of equal runs wins. The final tap is the best run's ending tap minus floor(best length / 2), reported on `cal_phase`.
- R9: If no tap passes, the block ends with `done`=1 and `err`=1 and the delay line returns to pass-through.
- R10: On success, `done`=1 and `err`=0, and the final tap stays on `dl_tap` with `dl_en`=1 and `dl_smp_en`=0 until the next start. A `start` pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins calibration when idle or done |
| dl_len_vld | input | 1 | Line-length measurement valid |
| dl_len | input | LEN_W | Measured line length (one bit per covered stage) |
| chk_pass | input | 1 | Tuning check passed at the probed tap |
| chk_fail | input | 1 | Tuning check failed at the probed tap |
| dl_en | output | 1 | Delay line enable |
| dl_smp_en | output | 1 | Length sampler enable |
| dl_unit | output | UNIT_W | Unit delay code to the line |
| dl_tap | output | TAP_W | Output tap select to the line |
| chk_req | output | 1 | One-cycle request to test the current tap |
| cal_unit | output | UNIT_W | Accepted unit delay code |
| cal_max_tap | output | TAP_W | Largest usable tap |
| cal_phase | output | TAP_W | Chosen sampling tap |
| done | output | 1 | Sequence finished (held until next start) |
| err | output | 1 | Sequence finished without a result |

## Verification
The bench builds the block with CYC_PER_US=2 and TIMEOUT_US=3, so a silent unit code times out after six waiting cycles. This lets the bench count the exact cycles spent on a code and makes a full sweep of all 128 unit codes to the no-result error affordable. The bench keeps the default widths and 11 delay stages, so the 2^11 acceptance limit and the maximum tap of 10 are exercised as they stand. A ported length model and a per-tap pass mask let directed cases reach equal-length runs, all-pass and no-pass sweeps, and a start pulse issued during a run.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LSET,
    S_LWAIT,
    S_PSET,
    S_PWAIT,
    S_FIN,
    S_DONE
  } dlc_state_e;
endpackage

// File: rtl/dlc_timeout.sv
module dlc_timeout #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (run && cnt != CW'(LIMIT - 1)) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/dlc_msb.sv
module dlc_msb #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  vec,
  output logic [OUT_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < IN_W; i++) begin
      if (vec[i]) idx = OUT_W'(i);
    end
  end
endmodule

// File: rtl/dlc_run_track.sv
module dlc_run_track #(
  parameter int RUN_W = 5,
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic             pass,
  input  logic [TAP_W-1:0] tap,
  output logic [RUN_W-1:0] best_len,
  output logic [TAP_W-1:0] best_end
);
  logic [RUN_W-1:0] cur;
  logic [RUN_W-1:0] cur_inc;

  assign cur_inc = cur + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cur      <= '0;
      best_len <= '0;
      best_end <= '0;
    end else if (upd) begin
      if (!pass) begin
        cur <= '0;
      end else begin
        cur <= cur_inc;
        if (cur_inc > best_len) begin
          best_len <= cur_inc;
          best_end <= tap;
        end
      end
    end
  end
endmodule

// File: rtl/dlc_tuner.sv
module dlc_tuner
  import dlc_pkg::*;
#(
  parameter int UNIT_W     = 7,
  parameter int TAP_W      = 4,
  parameter int LEN_W      = 12,
  parameter int NB_DELAY   = 11,
  parameter int CYC_PER_US = 100,
  parameter int TIMEOUT_US = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dl_len_vld,
  input  logic [LEN_W-1:0]  dl_len,
  input  logic              chk_pass,
  input  logic              chk_fail,
  output logic              dl_en,
  output logic              dl_smp_en,
  output logic [UNIT_W-1:0] dl_unit,
  output logic [TAP_W-1:0]  dl_tap,
  output logic              chk_req,
  output logic [UNIT_W-1:0] cal_unit,
  output logic [TAP_W-1:0]  cal_max_tap,
  output logic [TAP_W-1:0]  cal_phase,
  output logic              done,
  output logic              err
);
  localparam int TO_CYC = CYC_PER_US * TIMEOUT_US;
  localparam int RUN_W  = TAP_W + 1;
  localparam logic [TAP_W-1:0] SAMPLE_TAP = TAP_W'(NB_DELAY + 1);

  dlc_state_e        st;
  logic [UNIT_W-1:0] unit_q;
  logic [TAP_W-1:0]  tap_q;

  logic              expired;
  logic [TAP_W-1:0]  len_msb;
  logic              len_ok;
  logic              answered;
  logic              trk_clr;
  logic [RUN_W-1:0]  best_len;
  logic [TAP_W-1:0]  best_end;
  logic [TAP_W-1:0]  final_tap;

  dlc_timeout #(.LIMIT(TO_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (st != S_LWAIT),
    .run     (st == S_LWAIT),
    .expired (expired)
  );

  dlc_msb #(.IN_W(LEN_W), .OUT_W(TAP_W)) u_msb (
    .vec (dl_len),
    .idx (len_msb)
  );

  assign len_ok   = dl_len_vld && (dl_len != '0) && ((dl_len >> NB_DELAY) == '0);
  assign answered = (st == S_PWAIT) && (chk_pass || chk_fail);
  assign trk_clr  = (st == S_LWAIT) && len_ok;

  dlc_run_track #(.RUN_W(RUN_W), .TAP_W(TAP_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .clr      (trk_clr),
    .upd      (answered),
    .pass     (chk_pass),
    .tap      (tap_q),
    .best_len (best_len),
    .best_end (best_end)
  );

  assign final_tap = best_end - TAP_W'(best_len >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      unit_q      <= '0;
      tap_q       <= '0;
      dl_en       <= 1'b0;
      dl_smp_en   <= 1'b0;
      dl_unit     <= '0;
      dl_tap      <= '0;
      chk_req     <= 1'b0;
      cal_unit    <= '0;
      cal_max_tap <= '0;
      cal_phase   <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start) begin
            unit_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
            st     <= S_LSET;
          end
        end
        S_LSET: begin
          dl_en     <= 1'b1;
          dl_smp_en <= 1'b1;
          dl_unit   <= unit_q;
          dl_tap    <= SAMPLE_TAP;
          st        <= S_LWAIT;
        end
        S_LWAIT: begin
          if (len_ok) begin
            cal_unit    <= unit_q;
            cal_max_tap <= len_msb;
            tap_q       <= '0;
            st          <= S_PSET;
          end else if (dl_len_vld || expired) begin
            if (unit_q == {UNIT_W{1'b1}}) begin
              dl_en     <= 1'b0;
              dl_smp_en <= 1'b0;
              dl_unit   <= '0;
              dl_tap    <= '0;
              err       <= 1'b1;
              done      <= 1'b1;
              st        <= S_DONE;
            end else begin
              unit_q <= unit_q + 1'b1;
              st     <= S_LSET;
            end
          end
        end
        S_PSET: begin
          dl_en     <= 1'b1;
          dl_smp_en <= 1'b0;
          dl_unit   <= cal_unit;
          dl_tap    <= tap_q;
          chk_req   <= 1'b1;
          st        <= S_PWAIT;
        end
        S_PWAIT: begin
          chk_req <= 1'b0;
          if (chk_pass || chk_fail) begin
            if (tap_q == cal_max_tap) begin
              st <= S_FIN;
            end else begin
              tap_q <= tap_q + 1'b1;
              st    <= S_PSET;
            end
          end
        end
        S_FIN: begin
          if (best_len == '0) begin
            dl_en     <= 1'b0;
            dl_smp_en <= 1'b0;
            dl_unit   <= '0;
            dl_tap    <= '0;
            err       <= 1'b1;
          end else begin
            dl_tap    <= final_tap;
            cal_phase <= final_tap;
          end
          done <= 1'b1;
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dlc_tuner_chk.sv
module dlc_tuner_chk #(
  parameter int TAP_W    = 4,
  parameter int NB_DELAY = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             dl_en,
  input logic             dl_smp_en,
  input logic [TAP_W-1:0] dl_tap,
  input logic             chk_req,
  input logic [TAP_W-1:0] cal_max_tap,
  input logic [TAP_W-1:0] cal_phase,
  input logic             done,
  input logic             err
);
  p_sample_tap_r2: assert property (@(posedge clk) disable iff (rst)
    dl_smp_en |-> (dl_en && dl_tap == TAP_W'(NB_DELAY + 1)));

  p_maxtap_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (cal_max_tap < TAP_W'(NB_DELAY)));

  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (!dl_en && !dl_smp_en && dl_tap == '0));

  p_probe_r7: assert property (@(posedge clk) disable iff (rst)
    chk_req |-> (dl_en && !dl_smp_en && dl_tap <= cal_max_tap && !done));

  p_phase_range_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (cal_phase <= cal_max_tap && dl_tap == cal_phase));

  p_err_done_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(dl_tap) && $stable(cal_phase)));
endmodule

bind dlc_tuner dlc_tuner_chk #(.TAP_W(TAP_W), .NB_DELAY(NB_DELAY)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start       (start),
  .dl_en       (dl_en),
  .dl_smp_en   (dl_smp_en),
  .dl_tap      (dl_tap),
  .chk_req     (chk_req),
  .cal_max_tap (cal_max_tap),
  .cal_phase   (cal_phase),
  .done        (done),
  .err         (err)
);

// File: tb/dlc_tuner_test.sv
module dlc_tuner_test;
  localparam int CLK_PERIOD = 10;
  localparam int UNIT_W = 7;
  localparam int TAP_W  = 4;
  localparam int LEN_W  = 12;
  localparam int NB_DEL = 11;
  localparam int CPU    = 2;
  localparam int TO_US  = 3;
  localparam int TO_CYC = CPU * TO_US;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic dl_len_vld = 1'b0;
  logic [LEN_W-1:0] dl_len = '0;
  logic chk_pass = 1'b0;
  logic chk_fail = 1'b0;
  logic dl_en, dl_smp_en, chk_req, done, err;
  logic [UNIT_W-1:0] dl_unit, cal_unit;
  logic [TAP_W-1:0] dl_tap, cal_max_tap, cal_phase;

  int n_chk = 0;
  int n_bad = 0;

  // scenario model settings
  int resp_from = 0;
  int good_unit = 0;
  logic [LEN_W-1:0] good_len = '0;
  logic [15:0] pass_mask = '0;

  // monitors
  int unit0_cycles = 0;
  int probe_n = 0;
  logic [TAP_W-1:0] probe_seq [16];
  int ctl_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dlc_tuner #(
    .UNIT_W(UNIT_W), .TAP_W(TAP_W), .LEN_W(LEN_W), .NB_DELAY(NB_DEL),
    .CYC_PER_US(CPU), .TIMEOUT_US(TO_US)
  ) uut (
    .clk(clk), .rst(rst), .start(start),
    .dl_len_vld(dl_len_vld), .dl_len(dl_len),
    .chk_pass(chk_pass), .chk_fail(chk_fail),
    .dl_en(dl_en), .dl_smp_en(dl_smp_en), .dl_unit(dl_unit), .dl_tap(dl_tap),
    .chk_req(chk_req), .cal_unit(cal_unit), .cal_max_tap(cal_max_tap),
    .cal_phase(cal_phase), .done(done), .err(err)
  );

  // delay line, checker model and monitors, all acting at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      dl_len_vld = dl_en && dl_smp_en && (int'(dl_unit) >= resp_from);
      if (int'(dl_unit) == good_unit) dl_len = good_len;
      else dl_len = dl_unit[0] ? 12'h800 : 12'h000;
      chk_pass = chk_req && pass_mask[dl_tap];
      chk_fail = chk_req && !pass_mask[dl_tap];
      if (dl_smp_en && dl_unit == '0) unit0_cycles++;
      if (dl_smp_en && (!dl_en || dl_tap != TAP_W'(NB_DEL + 1))) ctl_bad++;
      if (chk_req) begin
        if (probe_n < 16) probe_seq[probe_n] = dl_tap;
        probe_n++;
        if (dl_smp_en || !dl_en || dl_unit != cal_unit) ctl_bad++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int msb_of(input logic [LEN_W-1:0] v);
    int r = 0;
    for (int i = 0; i < LEN_W; i++) if (v[i]) r = i;
    return r;
  endfunction

  // longest run of passes, earliest on ties; returns -1 when none pass
  function automatic int exp_phase(input logic [15:0] m, input int maxt);
    int cur = 0, best = 0, bend = 0;
    for (int t = 0; t <= maxt; t++) begin
      if (m[t]) begin
        cur++;
        if (cur > best) begin best = cur; bend = t; end
      end else cur = 0;
    end
    if (best == 0) return -1;
    return bend - best / 2;
  endfunction

  task automatic launch(input int rf, input int gu, input logic [LEN_W-1:0] gl,
                        input logic [15:0] m, input int extra_start_at);
    int cyc = 0;
    resp_from = rf; good_unit = gu; good_len = gl; pass_mask = m;
    unit0_cycles = 0; probe_n = 0; ctl_bad = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && cyc < 5000) begin
      cyc++;
      if (cyc == extra_start_at) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic check_probes(input string req, input int maxt);
    check(req, probe_n, maxt + 1);
    for (int i = 0; i < probe_n && i < 16; i++) check(req, int'(probe_seq[i]), i);
  endtask

  task automatic t_reset;
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 chk_req", chk_req, 0);
    check("R1 dl_en", dl_en, 0);
    check("R1 dl_smp_en", dl_smp_en, 0);
    check("R1 dl_unit", int'(dl_unit), 0);
    check("R1 dl_tap", int'(dl_tap), 0);
  endtask

  task automatic t_basic;
    launch(0, 5, 12'h0F0, 16'b0111_0110, 0);
    check("R4 unit", int'(cal_unit), 5);
    check("R5 max tap", int'(cal_max_tap), msb_of(12'h0F0));
    check("R8 phase", int'(cal_phase), exp_phase(16'b0111_0110, 7));
    check("R10 err", err, 0);
    check("R2 ctl", ctl_bad, 0);
    check_probes("R7 probes", 7);
    repeat (20) @(negedge clk);
    check("R10 held done", done, 1);
    check("R10 held tap", int'(dl_tap), 5);
    check("R10 en", dl_en, 1);
    check("R10 smp", dl_smp_en, 0);
  endtask

  task automatic t_timeout;
    launch(3, 4, 12'h7FF, 16'hFFFF, 3);
    check("R3 silent code cycles", unit0_cycles, TO_CYC + 1);
    check("R4 boundary accept", int'(cal_unit), 4);
    check("R5 max tap 10", int'(cal_max_tap), 10);
    check("R8 all pass", int'(cal_phase), exp_phase(16'hFFFF, 10));
    check("R10 start ignored", err, 0);
    check_probes("R7 probes", 10);
  endtask

  task automatic t_tie;
    launch(0, 2, 12'h0A0, 16'b0011_0011, 0);
    check("R8 tie unit", int'(cal_unit), 2);
    check("R8 tie phase", int'(cal_phase), exp_phase(16'b0011_0011, 7));
    check("R8 tie dl_tap", int'(dl_tap), 0);
  endtask

  task automatic t_nopass;
    launch(0, 1, 12'h00F, 16'h0000, 0);
    check("R9 done", done, 1);
    check("R9 err", err, 1);
    check("R9 bypass en", dl_en, 0);
    check_probes("R9 probes", 3);
  endtask

  task automatic t_nounit;
    launch(0, 500, 12'h001, 16'hFFFF, 0);
    check("R6 done", done, 1);
    check("R6 err", err, 1);
    check("R6 bypass en", dl_en, 0);
    check("R6 bypass smp", dl_smp_en, 0);
    check("R6 no probes", probe_n, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_timeout();
    t_tie();
    t_nopass();
    t_nounit();
    t_basic();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule